// File: doc/BRIEF.md
# Soft-Start Peak Current-Limit Sequencer

This block produces the peak current-limit reference that a current-mode switching regulator compares against on every switching cycle. The output is a code in percent of the full limit. After a start pulse (or reset) the block climbs a timed staircase of nine levels, so that transformers and output capacitors charge gently. Once the staircase tops out, the limit follows a duty-dependent curve that rises with the measured on-time, which keeps the deliverable output power roughly constant across input line voltage.

The limit is not applied as it changes. It is captured on each falling edge of the gate-drive signal, as the smaller of the staircase level and the on-time curve. It then drives the next switching cycle. Until the first gate falling edge after a start, the held value is the lowest staircase level. The analog comparator and the sense resistor lie outside this block.

Top module: `softstart_ilim_seq`

## Requirements
- R1: During and right after reset, `ilim` is 45 and the staircase sits at its first level.
- R2: The staircase levels, in step order 0..8, are 45, 52, 59, 66, 73, 80, 86, 93 and 100 (percent of full limit).
- R3: The staircase advances one step every `CLK_PER_STEP` clock cycles, counted from the start edge (or reset). After step 8 (level 100) it stays there.
- R4: `ilim` changes only in the cycle after a gate falling edge or a start pulse. A gate falling edge is `gate` high in one cycle and low in the next. Between such events `ilim` holds its value, whatever `on_time` does.
- R5: On a gate falling edge, `ilim` becomes the minimum of the current staircase level and the on-time limit computed from `on_time` at that edge.
- R6: The on-time limit is a straight-line curve in `on_time` (measured in clock cycles):
  - from `VALLEY_PCT` (70) at 0 up to `MID_PCT` (85) at `TON_MID`;
  - from there up to 100 at `TON_FLAT`;
  - 100 at and above `TON_FLAT`;
  - values between these points are truncated toward zero.
- R7: A start pulse resets the staircase to step 0 and sets `ilim` to 45. If a start pulse and a gate falling edge fall in the same cycle, the start pulse wins.
- R8: A limit captured on a falling edge is visible from the next cycle. It stays unchanged through the whole following on-time, while `gate` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restart pulse; restarts the staircase |
| gate | input | 1 | Gate-drive signal; its falling edge captures the limit |
| on_time | input | TON_W | Measured on-time of the ending cycle, in clock cycles |
| ilim | output | 7 | Held current-limit code, percent of full limit |

## Verification
The bench builds the block with `CLK_PER_STEP` = 20, `TON_MID` = 40 and `TON_FLAT` = 80, with `TON_W` at its default. With these values the whole nine-step staircase fits in 160 cycles, so every level and the saturated top can be hit by timed falling edges. The shortened on-time knees let small random on-times cover all three segments of the line-compensation curve. They also reach the crossover where the staircase, rather than the on-time curve, sets the minimum.

// File: rtl/softstart_ilim_seq.sv
module softstart_ilim_seq #(
  parameter int CLK_PER_STEP = 64000,
  parameter int TON_W        = 12,
  parameter int TON_MID      = 400,
  parameter int TON_FLAT     = 800,
  parameter int VALLEY_PCT   = 70,
  parameter int MID_PCT      = 85
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             gate,
  input  logic [TON_W-1:0] on_time,
  output logic [6:0]       ilim
);
  localparam int LAST_STEP = 8;
  localparam int TMR_W     = $clog2(CLK_PER_STEP + 1);
  localparam logic [6:0] FIRST_LVL = 7'd45;

  function automatic logic [6:0] stair_lvl(input logic [3:0] s);
    case (s)
      4'd0:    return 7'd45;
      4'd1:    return 7'd52;
      4'd2:    return 7'd59;
      4'd3:    return 7'd66;
      4'd4:    return 7'd73;
      4'd5:    return 7'd80;
      4'd6:    return 7'd86;
      4'd7:    return 7'd93;
      default: return 7'd100;
    endcase
  endfunction

  function automatic logic [6:0] duty_lvl(input logic [TON_W-1:0] ton);
    int t;
    int v;
    t = int'(ton);
    if (t >= TON_FLAT)
      v = 100;
    else if (t >= TON_MID)
      v = MID_PCT + ((t - TON_MID) * (100 - MID_PCT)) / (TON_FLAT - TON_MID);
    else
      v = VALLEY_PCT + (t * (MID_PCT - VALLEY_PCT)) / TON_MID;
    return 7'(v);
  endfunction

  logic             gate_q;
  logic [3:0]       step;
  logic [TMR_W-1:0] tmr;
  logic [6:0]       held;
  logic [6:0]       stair_now, duty_now, cand;
  logic             fall;

  assign fall      = gate_q & ~gate;
  assign stair_now = stair_lvl(step);
  assign duty_now  = duty_lvl(on_time);
  assign cand      = (stair_now < duty_now) ? stair_now : duty_now;
  assign ilim      = held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      step   <= '0;
      tmr    <= '0;
      held   <= FIRST_LVL;
    end else begin
      gate_q <= gate;
      if (start) begin
        step <= '0;
        tmr  <= '0;
      end else if (step != 4'(LAST_STEP)) begin
        if (tmr == TMR_W'(CLK_PER_STEP - 1)) begin
          tmr  <= '0;
          step <= step + 4'd1;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
      if (start)
        held <= FIRST_LVL;
      else if (fall)
        held <= cand;
    end
  end

  AST_RESET_LEVEL: assert property (@(posedge clk) !rst_n |=> ilim == FIRST_LVL); // R1
  AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ilim >= FIRST_LVL && ilim <= 7'd100); // R2
  AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 4'(LAST_STEP)); // R3
  AST_STEP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> step >= $past(step)); // R3
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !fall) |=> $stable(ilim)); // R4
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ilim == FIRST_LVL && step == 4'd0)); // R7
  AST_HOLD_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && gate_q && !start) |=> $stable(ilim)); // R8
endmodule

// File: tb/softstart_ilim_seq_test.sv
module softstart_ilim_seq_test;
  localparam int CPS   = 20;
  localparam int TW    = 12;
  localparam int TMID  = 40;
  localparam int TFLAT = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic gate = 1'b0;
  logic [TW-1:0] on_time = '0;
  logic [6:0] ilim;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  softstart_ilim_seq #(.CLK_PER_STEP(CPS), .TON_W(TW), .TON_MID(TMID),
    .TON_FLAT(TFLAT), .VALLEY_PCT(70), .MID_PCT(85)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .gate(gate),
    .on_time(on_time), .ilim(ilim));

  function automatic int lvl_of(input int k);
    int tbl [9] = '{45, 52, 59, 66, 73, 80, 86, 93, 100};
    return tbl[(k > 8) ? 8 : k];
  endfunction

  function automatic int curve(input int t);
    if (t >= TFLAT) return 100;
    if (t >= TMID) return 85 + ((t - TMID) * 15) / (TFLAT - TMID);
    return 70 + (t * 15) / TMID;
  endfunction

  int cnt_m;
  int exp_m;
  logic gate_p;
  always @(posedge clk) begin
    if (!rst_n) begin
      cnt_m <= 0; exp_m <= 45; gate_p <= 1'b0;
    end else begin
      gate_p <= gate;
      cnt_m <= start ? 0 : ((cnt_m < 100000) ? cnt_m + 1 : cnt_m);
      if (start) exp_m <= 45;
      else if (gate_p && !gate) begin
        int a;
        int b;
        a = lvl_of(cnt_m / CPS);
        b = curve(int'(on_time));
        exp_m <= (a < b) ? a : b;
      end
    end
  end

  task automatic chk(input int act, input int expv, input string t);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: ilim=%0d expected %0d at %0t", t, act, expv, $time);
    end
  endtask

  always @(negedge clk) if (live) chk(int'(ilim), exp_m, tag);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse(input int ton, input int hi);
    on_time = TW'(ton);
    gate = 1'b1;
    cyc(hi);
    gate = 1'b0;
    cyc(1);
  endtask

  initial begin
    cyc(3);
    chk(int'(ilim), 45, "R1");
    rst_n = 1'b1;
    cyc(2);
    chk(int'(ilim), 45, "R1");
    live = 1'b1;

    tag = "R2";
    do_start();
    for (int k = 0; k < 9; k++) begin
      while (cnt_m != k * CPS + 6) @(negedge clk);
      pulse(300, 3);
      chk(int'(ilim), lvl_of(k), "R2");
    end

    tag = "R3";
    cyc(60);
    pulse(300, 4);
    chk(int'(ilim), 100, "R3");

    tag = "R6";
    pulse(0, 2);  chk(int'(ilim), 70, "R6");
    pulse(20, 2); chk(int'(ilim), 77, "R6");
    pulse(40, 2); chk(int'(ilim), 85, "R6");
    pulse(60, 2); chk(int'(ilim), 92, "R6");
    pulse(80, 2); chk(int'(ilim), 100, "R6");
    pulse(79, 2); chk(int'(ilim), 99, "R6");

    tag = "R8";
    on_time = TW'(0);
    gate = 1'b1;
    cyc(5);
    chk(int'(ilim), 99, "R8");
    gate = 1'b0;
    cyc(1);
    chk(int'(ilim), 70, "R8");

    tag = "R4";
    for (int i = 0; i < 8; i++) begin
      on_time = TW'(i * 13);
      cyc(1);
    end
    chk(int'(ilim), 70, "R4");

    tag = "R5";
    do_start();
    chk(int'(ilim), 45, "R7");
    cyc(82);
    pulse(0, 3);
    chk(int'(ilim), 70, "R5");
    pulse(20, 2);
    chk(int'(ilim), 73, "R5");

    tag = "R7";
    on_time = TW'(300);
    gate = 1'b1;
    cyc(3);
    gate = 1'b0;
    start = 1'b1;
    cyc(1);
    start = 1'b0;
    chk(int'(ilim), 45, "R7");
    cyc(2);
    pulse(300, 2);
    chk(int'(ilim), 45, "R7");

    tag = "R5";
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 24) == 0) begin
        start = 1'b1;
        cyc(1);
        start = 1'b0;
      end
      pulse(int'($urandom_range(0, 120)), int'($urandom_range(1, 10)));
      cyc(int'($urandom_range(0, 10)));
    end

    live = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule